// File: doc/BRIEF.md
# Two-Word Burst SRAM Host Controller

This controller sits between a user request port and a synchronous SRAM with separate data-in and data-out buses and a fixed burst of two 18-bit words. It runs on a clock at twice the command rate. Each pair of internal cycles forms one command cycle. The first cycle of the pair is the rising command edge, and it is brought out as `memK`. A request accepted from the user becomes one command on the memory pins. Write data is split into two beats, each with its own byte mask. The two beats of read data are captured at the latency the memory's latency strap selects and returned as one 36-bit word with an ordering tag.

Several memory banks can share the address, data and control pins. Each bank has its own active-low load strobe. Requests are accepted once per command cycle. Any mix of reads and writes can follow each other with no idle command cycles. The only limit is the number of reads still waiting for their data.

Top module: `bsram_ctrl`

## Requirements
- R1: `reqReady` is high only in the second internal cycle of a command cycle (the cycle in which `memK` is low), only when out of reset, and only when fewer than RD_DEPTH reads are outstanding. A request is taken at a clock edge where `reqValid` and `reqReady` are both high.
- R2: A request accepted at the edge that ends slot s is issued during slots s+1 and s+2, and slot s+1 has `memK` high. For those two slots `memLoadN` has the addressed bank's bit low and the other bits high, `memRw` is 1 for a read and 0 for a write, and `memAddr` holds `reqAddr`.
- R3: In a slot with no command, all `memLoadN` bits are high, `memRw` is 1 and `memAddr` is 0.
- R4: For a write issued at slot t, `memD` carries `reqData[17:0]` with `memBwN = ~reqBe[1:0]` in slot t+2 (`memK` high). It carries `reqData[35:18]` with `memBwN = ~reqBe[3:2]` in slot t+3. Mask bit 0 covers data bits 8:0 of a beat and bit 1 covers bits 17:9. In every other slot `memD` is 0 and `memBwN` is 2'b11.
- R5: With `legacyMode` low, a read issued at slot t samples the lower word from `memQ` in slot t+3 and the upper word in slot t+4.
- R6: With `legacyMode` high, a read issued at slot t samples the lower word in slot t+2 and the upper word in slot t+3.
- R7: `rspValid` pulses for one cycle in the slot after the upper word is sampled, with `rspData = {upper, lower}`. Responses come back in request order.
- R8: `rspTag` is the number of earlier read responses since reset, modulo 2^TW.
- R9: A read counts as outstanding from its acceptance until its upper word is sampled. While RD_DEPTH reads are outstanding, no request is accepted.
- R10: Any mix of reads and writes is accepted on consecutive command cycles when R9 does not hold back a read.
- R11: At most one `memLoadN` bit is low in any slot. Data written to one bank does not appear in reads of another bank.
- R12: While `rstN` is low, `reqReady` and `rspValid` are 0 and all `memLoadN` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rstN | input | 1 | Synchronous active-low reset |
| legacyMode | input | 1 | Latency strap: 1 selects one-cycle read latency |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken at this edge if valid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBank | input | BW | Bank select |
| reqAddr | input | AW | Burst address |
| reqData | input | 36 | Write data, lower beat in bits 17:0 |
| reqBe | input | 4 | Active-high byte enables, two per beat |
| rspValid | output | 1 | Read response pulse |
| rspData | output | 36 | Read data, lower word in bits 17:0 |
| rspTag | output | TW | Response ordering tag |
| memK | output | 1 | Command clock, high in the first slot of each command cycle |
| memLoadN | output | NB | Per-bank active-low load strobe |
| memRw | output | 1 | 1 for read, 0 for write |
| memAddr | output | AW | Shared address |
| memD | output | 18 | Write data beat |
| memBwN | output | 2 | Active-low byte write selects |
| memQ | input | 18 | Read data beat from the memory |

## Verification
A read-capture pipe that is off by one slot returns the neighbouring word or bus filler in `rspData` on the very first read. This is because the memory model drives `memQ` only in the slots that belong to the strap's latency. A wrong outstanding count shows up as a changed acceptance spacing in the first burst of three reads. It can also show as a response tag that skips a value. A beat-staging fault corrupts the merged word that a later read of the same address returns. The command timing of every request is compared against the slot in which the request was accepted, so a misplaced load strobe is reported on that request.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef struct packed {
    logic launch;       // request taken at this edge
    logic launchWrite;  // taken request is a write
    logic cmdEdge;      // edge that opens a new command cycle
    logic wrBeat0;      // load lower write beat onto pins
    logic wrBeat1;      // load upper write beat onto pins
    logic capLow;       // sample lower read word
    logic capHigh;      // sample upper read word, emit response
  } strobeT;
endpackage

// File: rtl/bsram_ctrl_seq.sv
module bsram_ctrl_seq
  import bsram_pkg::*;
#(
  parameter int RD_DEPTH = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   legacyMode,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output logic   memK,
  output strobeT strb
);
  localparam int CW = $clog2(RD_DEPTH + 1);
  localparam int RD_STAGES = 5;
  localparam int WR_STAGES = 3;

  logic                 phase;
  logic [RD_STAGES-1:0] rdPipe;
  logic [WR_STAGES-1:0] wrPipe;
  logic [CW-1:0]        outCount;
  logic                 accept;

  assign reqReady = rstN && phase && (outCount < CW'(RD_DEPTH));
  assign accept   = reqValid && reqReady;
  assign memK     = ~phase;

  always_comb begin
    strb.launch      = accept;
    strb.launchWrite = reqWrite;
    strb.cmdEdge     = phase;
    strb.wrBeat0     = wrPipe[1];
    strb.wrBeat1     = wrPipe[2];
    strb.capLow      = legacyMode ? rdPipe[2] : rdPipe[3];
    strb.capHigh     = legacyMode ? rdPipe[3] : rdPipe[4];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= 1'b0;
      rdPipe   <= '0;
      wrPipe   <= '0;
      outCount <= '0;
    end else begin
      phase    <= ~phase;
      rdPipe   <= {rdPipe[RD_STAGES-2:0], accept && !reqWrite};
      wrPipe   <= {wrPipe[WR_STAGES-2:0], accept && reqWrite};
      outCount <= outCount + CW'(accept && !reqWrite) - CW'(strb.capHigh);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    outCount <= CW'(RD_DEPTH)); // R9
  AST_ONE_ACCEPT_PER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady); // R1
  AST_CAPTURE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    strb.capHigh |-> $past(strb.capLow)); // R5
endmodule

// File: rtl/bsram_ctrl_data.sv
module bsram_ctrl_data
  import bsram_pkg::*;
#(
  parameter int AW = 20,
  parameter int NB = 2,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic [((NB > 1) ? $clog2(NB) : 1)-1:0] reqBank,
  input  logic [AW-1:0] reqAddr,
  input  logic [35:0]   reqData,
  input  logic [3:0]    reqBe,
  input  logic [17:0]   memQ,
  output logic [NB-1:0] memLoadN,
  output logic          memRw,
  output logic [AW-1:0] memAddr,
  output logic [17:0]   memD,
  output logic [1:0]    memBwN,
  output logic          rspValid,
  output logic [35:0]   rspData,
  output logic [TW-1:0] rspTag
);
  logic [35:0]   wrHold;
  logic [3:0]    beHold;
  logic [17:0]   hiData;
  logic [1:0]    hiBe;
  logic [17:0]   loWord;
  logic [TW-1:0] nextTag;

  // command pins: change only at the edge that opens a command cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memLoadN <= '1;
      memRw    <= 1'b1;
      memAddr  <= '0;
      wrHold   <= '0;
      beHold   <= '0;
    end else if (strb.cmdEdge) begin
      if (strb.launch) begin
        memLoadN <= ~(NB'(1) << reqBank);
        memRw    <= ~strb.launchWrite;
        memAddr  <= reqAddr;
        if (strb.launchWrite) begin
          wrHold <= reqData;
          beHold <= reqBe;
        end
      end else begin
        memLoadN <= '1;
        memRw    <= 1'b1;
        memAddr  <= '0;
      end
    end
  end

  // write beats: upper beat staged so a following write can refill wrHold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memD   <= '0;
      memBwN <= 2'b11;
      hiData <= '0;
      hiBe   <= '0;
    end else if (strb.wrBeat0) begin
      memD   <= wrHold[17:0];
      memBwN <= ~beHold[1:0];
      hiData <= wrHold[35:18];
      hiBe   <= beHold[3:2];
    end else if (strb.wrBeat1) begin
      memD   <= hiData;
      memBwN <= ~hiBe;
    end else begin
      memD   <= '0;
      memBwN <= 2'b11;
    end
  end

  // read capture and in-order response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loWord   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      rspTag   <= '0;
      nextTag  <= '0;
    end else begin
      rspValid <= strb.capHigh;
      if (strb.capLow) loWord <= memQ;
      if (strb.capHigh) begin
        rspData <= {memQ, loWord};
        rspTag  <= nextTag;
        nextTag <= nextTag + 1'b1;
      end
    end
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~memLoadN) <= 1); // R11
  AST_CMD_TWO_SLOTS: assert property (@(posedge clk) disable iff (!rstN)
    (memLoadN != '1 && $past(memLoadN) == '1) |=> $stable(memLoadN)); // R2
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (memLoadN == '1) |-> (memRw && memAddr == '0)); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW       = 20,
  parameter int NB       = 2,
  parameter int TW       = 4,
  parameter int RD_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          legacyMode,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [((NB > 1) ? $clog2(NB) : 1)-1:0] reqBank,
  input  logic [AW-1:0] reqAddr,
  input  logic [35:0]   reqData,
  input  logic [3:0]    reqBe,
  output logic          rspValid,
  output logic [35:0]   rspData,
  output logic [TW-1:0] rspTag,
  output logic          memK,
  output logic [NB-1:0] memLoadN,
  output logic          memRw,
  output logic [AW-1:0] memAddr,
  output logic [17:0]   memD,
  output logic [1:0]    memBwN,
  input  logic [17:0]   memQ
);
  strobeT strb;

  bsram_ctrl_seq #(.RD_DEPTH(RD_DEPTH)) i_seq (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .memK(memK), .strb(strb)
  );

  bsram_ctrl_data #(.AW(AW), .NB(NB), .TW(TW)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqBank(reqBank), .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .memQ(memQ), .memLoadN(memLoadN), .memRw(memRw), .memAddr(memAddr),
    .memD(memD), .memBwN(memBwN),
    .rspValid(rspValid), .rspData(rspData), .rspTag(rspTag)
  );
endmodule

// File: tb/test_bsram_ctrl.sv
`timescale 1ns/1ps
module test_bsram_ctrl;
  localparam int AW = 20;
  localparam int NB = 2;
  localparam int TW = 4;
  localparam int RD_DEPTH = 2;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rstN, legacyMode, reqValid, reqReady, reqWrite, rspValid, memK, memRw;
  logic [0:0] reqBank;
  logic [AW-1:0] reqAddr, memAddr;
  logic [35:0] reqData, rspData;
  logic [3:0] reqBe;
  logic [TW-1:0] rspTag;
  logic [NB-1:0] memLoadN;
  logic [17:0] memD, memQ;
  logic [1:0] memBwN;

  always #2 clk = ~clk; // 250 MHz

  bsram_ctrl #(.AW(AW), .NB(NB), .TW(TW), .RD_DEPTH(RD_DEPTH)) i_bsram_ctrl (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .rspTag(rspTag),
    .memK(memK), .memLoadN(memLoadN), .memRw(memRw), .memAddr(memAddr),
    .memD(memD), .memBwN(memBwN), .memQ(memQ)
  );

  int nCmp = 0, nBad = 0, slot = 0, cycles = 0;
  logic [35:0] shadow [NB][16];
  logic [35:0] model [NB][16];
  logic [35:0] expData[$];
  logic [TW-1:0] expTag[$];
  logic [TW-1:0] tagCount;
  logic [21:0] cmdQ[$];
  int cmdT0[$];
  int wrKind[16], rdKind[16];
  logic [3:0] wrA[16], rdA[16];
  int wrB[16], rdB[16];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
      finishRun();
    end
  end

  // memory model, pin checks and response monitor
  always @(negedge clk) begin
    slot++;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin wrKind[i] = 0; rdKind[i] = 0; end
      memQ = 18'h2aaaa;
    end else begin
      int s;
      s = slot % 16;
      if (wrKind[s] != 0) begin
        for (int b = 0; b < 2; b++)
          if (!memBwN[b])
            model[wrB[s]][wrA[s]][(wrKind[s]-1)*18 + b*9 +: 9] = memD[b*9 +: 9];
        wrKind[s] = 0;
      end else
        check(memBwN == 2'b11 && memD == 0, "R4 idle beat", {memBwN, memD}, {2'b11, 18'h0});
      if (memLoadN == '1)
        check(memRw && memAddr == 0, "R3 idle pins", {memRw, memAddr}, {1'b1, 20'h0});
      else if (memK) begin
        logic [21:0] got, exp;
        int bank, t0, lat;
        bank = memLoadN[0] ? 1 : 0;
        got = {!memRw, 1'(bank), memAddr};
        exp = (cmdQ.size() > 0) ? cmdQ.pop_front() : '1;
        t0 = (cmdT0.size() > 0) ? cmdT0.pop_front() : -1;
        check(got == exp && t0 == slot && $countones(~memLoadN) == 1,
              "R2 R11 command", {got, 32'(slot)}, {exp, 32'(t0)});
        if (!memRw) begin
          wrKind[(slot+2)%16] = 1; wrA[(slot+2)%16] = memAddr[3:0]; wrB[(slot+2)%16] = bank;
          wrKind[(slot+3)%16] = 2; wrA[(slot+3)%16] = memAddr[3:0]; wrB[(slot+3)%16] = bank;
        end else begin
          lat = legacyMode ? 2 : 3; // R5 R6
          rdKind[(slot+lat)%16] = 1; rdA[(slot+lat)%16] = memAddr[3:0]; rdB[(slot+lat)%16] = bank;
          rdKind[(slot+lat+1)%16] = 2; rdA[(slot+lat+1)%16] = memAddr[3:0]; rdB[(slot+lat+1)%16] = bank;
        end
      end
      if (rdKind[s] != 0) begin
        memQ = model[rdB[s]][rdA[s]][(rdKind[s]-1)*18 +: 18];
        rdKind[s] = 0;
      end else
        memQ = 18'h2aaaa;
      if (rspValid) begin
        logic [35:0] ed;
        logic [TW-1:0] et;
        ed = (expData.size() > 0) ? expData.pop_front() : 'x;
        et = (expTag.size() > 0) ? expTag.pop_front() : 'x;
        check(rspData === ed, "R5 R6 R7 read data", 64'(rspData), 64'(ed));
        check(rspTag === et, "R8 tag", 64'(rspTag), 64'(et));
      end
    end
  end

  // driver: returns the slot in which the command appears
  task automatic issue(input bit wr, input int bank, input int addr,
                       input logic [35:0] data, input logic [3:0] be, output int t0);
    reqValid = 1'b1; reqWrite = wr; reqBank = 1'(bank);
    reqAddr = AW'(addr); reqData = data; reqBe = be;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    t0 = slot + 1;
    cmdQ.push_back({wr, 1'(bank), AW'(addr)});
    cmdT0.push_back(t0);
    if (wr) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) shadow[bank][addr%16][i*9 +: 9] = data[i*9 +: 9];
    end else begin
      expData.push_back(shadow[bank][addr%16]);
      expTag.push_back(tagCount);
      tagCount++;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic resetPhase(input bit legacy);
    rstN = 1'b0; legacyMode = legacy; reqValid = 1'b0; tagCount = '0;
    expData.delete(); expTag.delete(); cmdQ.delete(); cmdT0.delete();
    repeat (4) @(negedge clk);
    check(!reqReady, "R12 ready in reset", 64'(reqReady), 0);
    check(memLoadN == '1, "R12 load strobes in reset", 64'(memLoadN), 64'(2'b11));
    check(!rspValid, "R12 response in reset", 64'(rspValid), 0);
    rstN = 1'b1;
  endtask

  task automatic runSeq(input int base);
    int t, last;
    for (int i = 0; i < 4; i++) begin
      issue(1, 0, base + i, 36'h123456789 ^ (36'(i) << 20) ^ 36'(base), 4'hf, t);
      if (i > 0) check(t - last == 2, "R10 write burst spacing", 64'(t - last), 2);
      last = t;
    end
    issue(1, 1, base, 36'hfedcba987, 4'hf, t);
    issue(1, 1, base, 36'h0a5a5a5a5, 4'b0101, t); // R4 partial mask merge
    for (int i = 0; i < 3; i++) begin
      issue(0, 0, base + i, '0, '0, t);
      if (i == 1) check(t - last == 2, "R10 read after read spacing", 64'(t - last), 2);
      if (i == 2) check(t - last == 4, "R9 stall at depth", 64'(t - last), 4);
      last = t;
    end
    issue(0, 1, base, '0, '0, t);  // R11 bank 1 holds merged data
    issue(0, 0, base, '0, '0, t);  // R11 bank 0 unaffected
    repeat (12) @(negedge clk);
    issue(1, 0, base + 5, 36'h13579bdf1, 4'hf, last);
    issue(0, 0, base + 5, '0, '0, t);
    check(t - last == 2, "R10 write then read", 64'(t - last), 2); last = t;
    issue(1, 0, base + 5, 36'hfff000000, 4'b1000, t);
    check(t - last == 2, "R10 read then write", 64'(t - last), 2); last = t;
    issue(0, 0, base + 5, '0, '0, t);
    check(t - last == 2, "R10 mixed spacing", 64'(t - last), 2);
    repeat (20) @(negedge clk);
    check(expData.size() == 0, "R7 all responses returned", 64'(expData.size()), 0);
  endtask

  initial begin
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 16; a++) begin shadow[b][a] = '0; model[b][a] = '0; end
    reqWrite = 0; reqBank = 0; reqAddr = 0; reqData = 0; reqBe = 0; memQ = 18'h2aaaa;
    resetPhase(1'b0);
    runSeq(1);   // R5 normal latency
    @(negedge clk);
    resetPhase(1'b1);
    runSeq(2);   // R6 legacy latency
    finishRun();
  end
endmodule